// File: doc/BRIEF.md
# Dual-Channel Code and Span Register Bank

This block holds the digital state of a two-channel converter. Each channel keeps a 16-bit output code and a 4-bit output span. Both pass through an input register and then an active register. A serial front end hands the block decoded requests, and each request carries an opcode, a channel address or an all-channels flag, a buffer selector and a 16-bit data word. Write requests fill input registers only. Update requests move code and span together from the input registers into the active registers, so a range change and its new code reach the converter in the same cycle.

An update-all pin works alongside the serial updates. The pin is asynchronous and active low. It is synchronised to the clock and acts once per falling edge, but only when chip select is inactive at that point. A manual-span pin gives all channels a span taken from three strap pins. In that mode, update requests leave the stored active span alone. A 16-bit readback word shows the buffer chosen by the most recent request. A read request selects any buffer explicitly, and any other request points the readback at the buffer it touched. The block also decodes the span in force into a range code for each channel.

Top module: `dac_regbank`

## Requirements
- R1: While reset is asserted and after it is released, every input and active code is 0, every input and active span is 0000, and the readback points at channel 0's input code.
- R2: Opcode 1 writes req_data into the input code register, and opcode 2 writes req_data[3:0] into the input span register. The target is the channel req_ch, or every channel when req_all is 1. Neither opcode changes act_code, act_span or act_range.
- R3: Opcode 3 copies the input code and the input span of the addressed channel(s) into their active registers at the same clock edge. Channels that are not addressed keep their active values.
- R4: With req_all set, any opcode other than read acts on every channel at once.
- R5: A falling edge on upd_all_n updates every channel exactly as opcode 3 with req_all does. The update takes effect within four clock cycles, provided cs_n is high when the edge is sampled.
- R6: If cs_n is low when the falling edge of upd_all_n is sampled, that edge has no effect.
- R7: While manual_span is 1, each channel's act_span is {0, span_strap}. Updates made in that mode do not change the stored active span, which takes effect again once manual_span returns to 0.
- R8: Opcode 4 selects the buffer req_buf of channel req_ch for readback (0 input code, 1 active code, 2 input span, 3 active span). A span appears in rd_word[3:0] with rd_word[15:4] equal to zero. The active span shown is the span in force, so in manual mode it is the strap value.
- R9: After opcode 1 the readback shows the input code of req_ch. After opcode 2 it shows the input span of req_ch, and after opcode 3 it shows the active code of req_ch.
- R10: act_range for each channel decodes the span in force. Span 0 maps to range 0 (0 to 1x), 1 to 1 (0 to 2x), 2 to 2 (±2x), 3 to 3 (±1x), 4 to 4 (±0.5x) and 5 to 5 (−0.5x to 1.5x). Any other span maps to range 0.
- R11: Holding upd_all_n low causes only one update. A code written while the pin stays low does not reach the active register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | 0 none, 1 write code, 2 write span, 3 update, 4 read |
| req_all | input | 1 | Address every channel |
| req_ch | input | 1 | Channel index |
| req_buf | input | 2 | Buffer selected by a read |
| req_data | input | 16 | Write data |
| upd_all_n | input | 1 | Asynchronous update-all pin, active low |
| cs_n | input | 1 | Chip-select level, low locks out the pin |
| manual_span | input | 1 | Take span from strap pins |
| span_strap | input | 3 | Strapped span code |
| act_code | output | 32 | Active codes, channel 0 in the low bits |
| act_span | output | 8 | Span in force per channel |
| act_range | output | 6 | Decoded range per channel |
| rd_word | output | 16 | Readback word |

## Verification
The main traffic is a long stream of seeded random requests. It mixes opcodes, channels, the all-channels flag, buffer selectors and data. Some bursts run in manual mode with random strap values, which separates the stored span from the span in force. Directed cases come before the random stream. A write followed by no update shows that input and active registers are kept apart. A single-channel update shows the two channels are isolated. Pulses on the update pin with chip select high and then low exercise the lockout. The pin is also held low across a later write, which shows the edge detection fires once. Span codes 6 to 15 exercise the default range decode.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;

  localparam int SPAN_W  = 4;
  localparam int RANGE_W = 3;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_WR_CODE = 3'd1,
    OP_WR_SPAN = 3'd2,
    OP_UPDATE  = 3'd3,
    OP_READ    = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    BUF_IN_CODE  = 2'd0,
    BUF_ACT_CODE = 2'd1,
    BUF_IN_SPAN  = 2'd2,
    BUF_ACT_SPAN = 2'd3
  } buf_e;

  typedef enum logic [RANGE_W-1:0] {
    RNG_UNI_1X   = 3'd0,
    RNG_UNI_2X   = 3'd1,
    RNG_BIP_2X   = 3'd2,
    RNG_BIP_1X   = 3'd3,
    RNG_BIP_HALF = 3'd4,
    RNG_OFFSET   = 3'd5
  } range_e;

  function automatic range_e span_to_range(input logic [SPAN_W-1:0] code);
    range_e r;
    case (code)
      4'd0:    r = RNG_UNI_1X;
      4'd1:    r = RNG_UNI_2X;
      4'd2:    r = RNG_BIP_2X;
      4'd3:    r = RNG_BIP_1X;
      4'd4:    r = RNG_BIP_HALF;
      4'd5:    r = RNG_OFFSET;
      default: r = RNG_UNI_1X;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic cs_n,
  output logic fire
);

  logic [STAGES-1:0] pin_sh_q, pin_sh_d;
  logic [STAGES-1:0] cs_sh_q, cs_sh_d;
  logic              pin_prev_q, pin_prev_d;
  logic              pin_s, cs_s;

  assign pin_s = pin_sh_q[STAGES-1];
  assign cs_s  = cs_sh_q[STAGES-1];

  always_comb begin
    pin_sh_d   = {pin_sh_q[STAGES-2:0], pin_n};
    cs_sh_d    = {cs_sh_q[STAGES-2:0], cs_n};
    pin_prev_d = pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sh_q   <= '1;
      cs_sh_q    <= '1;
      pin_prev_q <= 1'b1;
    end else begin
      pin_sh_q   <= pin_sh_d;
      cs_sh_q    <= cs_sh_d;
      pin_prev_q <= pin_prev_d;
    end
  end

  // one pulse per high-to-low transition, gated by chip select sampled alongside
  assign fire = pin_prev_q && !pin_s && cs_s;

endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
  import dac_regbank_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = SPAN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_code,
  input  logic          wr_span,
  input  logic          upd,
  input  logic          manual,
  input  logic [2:0]    strap,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] in_code,
  output logic [DW-1:0] act_code,
  output logic [SW-1:0] in_span,
  output logic [SW-1:0] eff_span,
  output logic [RANGE_W-1:0] range
);

  logic [DW-1:0] in_code_q, in_code_d;
  logic [DW-1:0] act_code_q, act_code_d;
  logic [SW-1:0] in_span_q, in_span_d;
  logic [SW-1:0] act_span_q, act_span_d;
  logic          in_code_en, act_code_en, in_span_en, act_span_en;

  assign in_code_en  = wr_code;
  assign in_span_en  = wr_span;
  assign act_code_en = upd;
  assign act_span_en = upd && !manual;

  always_comb begin
    in_code_d  = in_code_q;
    act_code_d = act_code_q;
    in_span_d  = in_span_q;
    act_span_d = act_span_q;
    if (in_code_en)  in_code_d  = wdata;
    if (in_span_en)  in_span_d  = wdata[SW-1:0];
    if (act_code_en) act_code_d = in_code_q;
    if (act_span_en) act_span_d = in_span_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_code_q  <= '0;
      act_code_q <= '0;
      in_span_q  <= '0;
      act_span_q <= '0;
    end else begin
      in_code_q  <= in_code_d;
      act_code_q <= act_code_d;
      in_span_q  <= in_span_d;
      act_span_q <= act_span_d;
    end
  end

  assign in_code  = in_code_q;
  assign act_code = act_code_q;
  assign in_span  = in_span_q;
  assign eff_span = manual ? SW'(strap) : act_span_q;
  assign range    = span_to_range(eff_span);

endmodule

// File: rtl/dac_readback.sv
module dac_readback
  import dac_regbank_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 16,
  parameter int SW  = SPAN_W,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [CHW-1:0]    ptr_ch,
  input  logic [1:0]        ptr_buf,
  input  logic [NCH*DW-1:0] in_code_all,
  input  logic [NCH*DW-1:0] act_code_all,
  input  logic [NCH*SW-1:0] in_span_all,
  input  logic [NCH*SW-1:0] eff_span_all,
  output logic [DW-1:0]     rd_word
);

  always_comb begin
    int sel;
    sel     = int'(ptr_ch);
    rd_word = '0;
    if (sel < NCH) begin
      case (ptr_buf)
        BUF_IN_CODE:  rd_word = in_code_all[sel*DW +: DW];
        BUF_ACT_CODE: rd_word = act_code_all[sel*DW +: DW];
        BUF_IN_SPAN:  rd_word = {{(DW-SW){1'b0}}, in_span_all[sel*SW +: SW]};
        default:      rd_word = {{(DW-SW){1'b0}}, eff_span_all[sel*SW +: SW]};
      endcase
    end
  end

endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
  import dac_regbank_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SW  = SPAN_W,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [2:0]             req_op,
  input  logic                   req_all,
  input  logic [CHW-1:0]         req_ch,
  input  logic [1:0]             req_buf,
  input  logic [DW-1:0]          req_data,
  input  logic                   upd_all_n,
  input  logic                   cs_n,
  input  logic                   manual_span,
  input  logic [2:0]             span_strap,
  output logic [NCH*DW-1:0]      act_code,
  output logic [NCH*SW-1:0]      act_span,
  output logic [NCH*RANGE_W-1:0] act_range,
  output logic [DW-1:0]          rd_word
);

  logic            pin_upd;
  logic            is_wr_code, is_wr_span, is_upd, is_read;
  logic [NCH-1:0]  ch_hit;
  logic [NCH-1:0]  upd_vec;
  logic            upd_any;
  logic [CHW-1:0]  ptr_ch_q, ptr_ch_d;
  logic [1:0]      ptr_buf_q, ptr_buf_d;
  logic            ptr_en;

  logic [NCH*DW-1:0] in_code_all;
  logic [NCH*SW-1:0] in_span_all;

  dac_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (upd_all_n),
    .cs_n  (cs_n),
    .fire  (pin_upd)
  );

  assign is_wr_code = req_valid && (req_op == OP_WR_CODE);
  assign is_wr_span = req_valid && (req_op == OP_WR_SPAN);
  assign is_upd     = req_valid && (req_op == OP_UPDATE);
  assign is_read    = req_valid && (req_op == OP_READ);

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic [DW-1:0] ch_in_code, ch_act_code;
    logic [SW-1:0] ch_in_span, ch_eff_span;
    logic [RANGE_W-1:0] ch_range;

    assign ch_hit[i]  = req_all || (int'(req_ch) == i);
    assign upd_vec[i] = (is_upd && ch_hit[i]) || pin_upd;

    dac_chan_regs #(.DW(DW), .SW(SW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_code  (is_wr_code && ch_hit[i]),
      .wr_span  (is_wr_span && ch_hit[i]),
      .upd      (upd_vec[i]),
      .manual   (manual_span),
      .strap    (span_strap),
      .wdata    (req_data),
      .in_code  (ch_in_code),
      .act_code (ch_act_code),
      .in_span  (ch_in_span),
      .eff_span (ch_eff_span),
      .range    (ch_range)
    );

    assign in_code_all[i*DW +: DW]       = ch_in_code;
    assign act_code[i*DW +: DW]          = ch_act_code;
    assign in_span_all[i*SW +: SW]       = ch_in_span;
    assign act_span[i*SW +: SW]          = ch_eff_span;
    assign act_range[i*RANGE_W +: RANGE_W] = ch_range;
  end

  assign upd_any = |upd_vec;

  // readback pointer: explicit on read, otherwise follows the touched buffer
  assign ptr_en = is_read || is_wr_code || is_wr_span || is_upd;

  always_comb begin
    ptr_ch_d  = ptr_ch_q;
    ptr_buf_d = ptr_buf_q;
    if (ptr_en) begin
      ptr_ch_d = req_ch;
      if (is_read)         ptr_buf_d = req_buf;
      else if (is_wr_code) ptr_buf_d = BUF_IN_CODE;
      else if (is_wr_span) ptr_buf_d = BUF_IN_SPAN;
      else                 ptr_buf_d = BUF_ACT_CODE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_ch_q  <= '0;
      ptr_buf_q <= BUF_IN_CODE;
    end else begin
      ptr_ch_q  <= ptr_ch_d;
      ptr_buf_q <= ptr_buf_d;
    end
  end

  dac_readback #(.NCH(NCH), .DW(DW), .SW(SW)) u_readback (
    .ptr_ch       (ptr_ch_q),
    .ptr_buf      (ptr_buf_q),
    .in_code_all  (in_code_all),
    .act_code_all (act_code),
    .in_span_all  (in_span_all),
    .eff_span_all (act_span),
    .rd_word      (rd_word)
  );

endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk
  import dac_regbank_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 16,
  localparam int SW = SPAN_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [2:0]             req_op,
  input logic [1:0]             req_buf,
  input logic                   manual_span,
  input logic                   pin_upd,
  input logic                   upd_any,
  input logic [NCH*DW-1:0]      act_code,
  input logic [NCH*SW-1:0]      act_span,
  input logic [NCH*RANGE_W-1:0] act_range,
  input logic [DW-1:0]          rd_word
);

  AST_WRITE_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == OP_WR_CODE || req_op == OP_WR_SPAN) && !pin_upd)
      |=> $stable(act_code)); // R2

  AST_CODE_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_any |=> $stable(act_code)); // R3

  AST_PIN_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    pin_upd |=> !pin_upd); // R11

  AST_SPAN_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_READ && req_buf[1]) |=> (rd_word[DW-1:SW] == '0)); // R8

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_RANGE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      act_range[i*RANGE_W +: RANGE_W] <= RANGE_W'(RNG_OFFSET)); // R10
    AST_MANUAL_SPAN_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      manual_span |-> !act_span[i*SW + SW-1]); // R7
  end

endmodule

bind dac_regbank dac_regbank_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_buf     (req_buf),
  .manual_span (manual_span),
  .pin_upd     (pin_upd),
  .upd_any     (upd_any),
  .act_code    (act_code),
  .act_span    (act_span),
  .act_range   (act_range),
  .rd_word     (rd_word)
);

// File: tb/dac_regbank_tb.sv
`timescale 1ns/1ps
module dac_regbank_tb;

  localparam int NCH = 2;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [2:0]    req_op;
  logic          req_all;
  logic [0:0]    req_ch;
  logic [1:0]    req_buf;
  logic [DW-1:0] req_data;
  logic          upd_all_n;
  logic          cs_n;
  logic          manual_span;
  logic [2:0]    span_strap;
  logic [NCH*DW-1:0] act_code;
  logic [NCH*4-1:0]  act_span;
  logic [NCH*3-1:0]  act_range;
  logic [DW-1:0]     rd_word;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [15:0] m_in_code [NCH];
  logic [15:0] m_act_code[NCH];
  logic [3:0]  m_in_span [NCH];
  logic [3:0]  m_act_span[NCH];
  int          m_ptr_ch;
  int          m_ptr_buf;

  always #2 clk = ~clk;

  dac_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_all(req_all), .req_ch(req_ch), .req_buf(req_buf), .req_data(req_data),
    .upd_all_n(upd_all_n), .cs_n(cs_n), .manual_span(manual_span),
    .span_strap(span_strap), .act_code(act_code), .act_span(act_span),
    .act_range(act_range), .rd_word(rd_word)
  );

  function automatic logic [3:0] eff_span(int i);
    return manual_span ? {1'b0, span_strap} : m_act_span[i];
  endfunction

  function automatic logic [2:0] exp_range(logic [3:0] c);
    return (c <= 4'd5) ? c[2:0] : 3'd0;
  endfunction

  function automatic logic [15:0] exp_rd();
    case (m_ptr_buf)
      0: return m_in_code[m_ptr_ch];
      1: return m_act_code[m_ptr_ch];
      2: return {12'd0, m_in_span[m_ptr_ch]};
      default: return {12'd0, eff_span(m_ptr_ch)};
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NCH; i++) begin
      chk({tag, " act_code"},  act_code[i*DW +: DW], m_act_code[i]);
      chk({tag, " act_span"},  {12'd0, act_span[i*4 +: 4]}, {12'd0, eff_span(i)});
      chk({tag, " act_range"}, {13'd0, act_range[i*3 +: 3]}, {13'd0, exp_range(eff_span(i))});
    end
    chk({tag, " rd_word"}, rd_word, exp_rd());
  endtask

  task automatic model_update(int i);
    m_act_code[i] = m_in_code[i];
    if (!manual_span) m_act_span[i] = m_in_span[i];
  endtask

  task automatic do_req(logic [2:0] op, logic all, int ch, logic [1:0] bsel, logic [15:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_all = all; req_ch = ch[0:0];
    req_buf = bsel; req_data = data;
    @(posedge clk);
    #0.5;
    for (int i = 0; i < NCH; i++) begin
      if (all || ch == i) begin
        case (op)
          3'd1: m_in_code[i] = data;
          3'd2: m_in_span[i] = data[3:0];
          3'd3: model_update(i);
          default: ;
        endcase
      end
    end
    case (op)
      3'd1: begin m_ptr_ch = ch; m_ptr_buf = 0; end
      3'd2: begin m_ptr_ch = ch; m_ptr_buf = 2; end
      3'd3: begin m_ptr_ch = ch; m_ptr_buf = 1; end
      3'd4: begin m_ptr_ch = ch; m_ptr_buf = bsel; end
      default: ;
    endcase
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pin_pulse(logic cs_level);
    @(negedge clk);
    cs_n = cs_level;
    repeat (4) @(negedge clk);
    upd_all_n = 1'b0;
    repeat (5) @(negedge clk);
    upd_all_n = 1'b1;
    repeat (4) @(negedge clk);
    if (cs_level) for (int i = 0; i < NCH; i++) model_update(i);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2752));
    rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_all = 1'b0; req_ch = 1'b0;
    req_buf = 2'd0; req_data = '0; upd_all_n = 1'b1; cs_n = 1'b1;
    manual_span = 1'b0; span_strap = 3'd0;
    for (int i = 0; i < NCH; i++) begin
      m_in_code[i] = '0; m_act_code[i] = '0; m_in_span[i] = '0; m_act_span[i] = '0;
    end
    m_ptr_ch = 0; m_ptr_buf = 0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 after reset");

    // R2: writes alone do not move active outputs
    do_req(3'd1, 1'b0, 0, 2'd0, 16'hA5C3);
    check_all("R2 write code ch0");
    do_req(3'd2, 1'b0, 0, 2'd0, 16'hFFF3);
    check_all("R2 write span ch0 low bits");
    chk("R9 pointer after span write", rd_word, 16'h0003);
    // R3: single-channel update, other channel untouched
    do_req(3'd3, 1'b0, 0, 2'd0, 16'h0);
    check_all("R3 update ch0");
    chk("R3 code moved", act_code[15:0], 16'hA5C3);
    chk("R10 range bip1x", {13'd0, act_range[2:0]}, 16'd3);
    // R4: all-channel write and update
    do_req(3'd1, 1'b1, 1, 2'd0, 16'h1234);
    do_req(3'd2, 1'b1, 1, 2'd0, 16'h0005);
    do_req(3'd3, 1'b1, 0, 2'd0, 16'h0);
    check_all("R4 update all");
    // R8: explicit reads of each buffer
    for (int b = 0; b < 4; b++) begin
      do_req(3'd4, 1'b0, 1, b[1:0], 16'hDEAD);
      check_all("R8 read buffer");
    end
    // R10: undefined span code decodes to range 0
    do_req(3'd2, 1'b0, 1, 2'd0, 16'h000E);
    do_req(3'd3, 1'b0, 1, 2'd0, 16'h0);
    check_all("R10 undefined span");
    chk("R10 undefined span range", {13'd0, act_range[5:3]}, 16'd0);
    // R5 / R6: update pin with and without lockout
    do_req(3'd1, 1'b1, 0, 2'd0, 16'h7777);
    pin_pulse(1'b0);
    check_all("R6 locked out pin");
    chk("R6 code held", act_code[15:0], 16'h1234);
    pin_pulse(1'b1);
    check_all("R5 pin update all");
    chk("R5 code moved", act_code[31:16], 16'h7777);
    // R11: held-low pin fires once
    @(negedge clk);
    upd_all_n = 1'b0;
    repeat (6) @(negedge clk);
    do_req(3'd1, 1'b0, 0, 2'd0, 16'h4242);
    repeat (6) @(negedge clk);
    check_all("R11 held pin no repeat");
    upd_all_n = 1'b1;
    repeat (6) @(negedge clk);
    // R7: manual mode overrides span and freezes stored active span
    manual_span = 1'b1; span_strap = 3'd6;
    @(negedge clk);
    check_all("R7 manual strap 6");
    do_req(3'd2, 1'b1, 0, 2'd0, 16'h0002);
    do_req(3'd3, 1'b1, 0, 2'd0, 16'h0);
    do_req(3'd4, 1'b0, 0, 2'd3, 16'h0);
    check_all("R7 manual update span frozen");
    chk("R7 span readback is strap", rd_word, 16'h0006);
    manual_span = 1'b0;
    @(negedge clk);
    check_all("R7 back to programmed span");

    // random traffic
    for (int it = 0; it < 600; it++) begin
      if (it % 75 == 0) begin
        @(negedge clk);
        manual_span = ($urandom % 3) == 0;
        span_strap  = 3'($urandom);
      end
      if (it % 97 == 50) pin_pulse(1'($urandom));
      do_req(3'($urandom % 5), ($urandom % 4) == 0, $urandom % NCH,
             2'($urandom), ($urandom % 3 == 0) ? 16'($urandom % 16) : 16'($urandom));
      check_all("R2 R3 R4 R8 R9 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule